// File: doc/BRIEF.md
# Indirect Multi-Channel Pulse-Shape Sample Memory

This block stores the programmable pulse shapes for a group of transmit channels. Each channel holds a fixed number of signed phase samples (eight channels of 24 seven-bit samples by default). A host does not address the storage directly. It programs a byte-wide address register that picks a channel and a phase index, then uses a byte-wide data register as a window onto the sample at that location.

A third byte register is a broadcast strobe. A write to it copies the most recently written sample value into the current phase index of every channel whose mask bit is set. All the selected channels are written in the same clock cycle. Each channel also has its own combinational read port, which the waveform playback logic uses to fetch samples by index.

There are two synchronous active-low resets. The power-up reset clears all of the state. The software reset clears only the address register and leaves the stored samples and the held sample value unchanged.

Top module: `wt_top`

## Requirements
- R1: The address register (host_sel = 0) reads back the last byte written to it. Bits [7:5] select the channel and bits [4:0] select the phase index. Either reset clears it to 00h.
- R2: A write to the data register (host_sel = 1) stores host_wdata[6:0] at the channel and phase held in the address register, and the stored value can be read back in the next cycle. Reading the data register returns the sample at the current address, combinationally.
- R3: Samples are 7-bit two's complement values and are kept bit-exact, including the extremes 3Fh (most positive) and 40h (most negative).
- R4: Phase indexes 24 to 31 hold no storage. Data and broadcast writes to them change nothing, and host and playback reads of them return zero.
- R5: A write to the broadcast register (host_sel = 2) with mask bit n set copies the held sample (the last value written to the data register) into channel n at the current phase index. All set bits take effect in the same cycle, and channels whose bit is clear are left unchanged.
- R6: The broadcast register self-clears, so it always reads 00h.
- R7: While the software reset is low, host writes are ignored and the address register clears. The stored samples and the held sample survive. The power-up reset clears the samples and the held sample to zero.
- R8: Bit 7 of a data register write is ignored, and bit 7 of a data register read is always 0.
- R9: Select code 3 maps to no register. Writes with it change nothing, and reads with it return 00h.
- R10: Playback port n (pb_idx[5n+4:5n]) returns channel n's sample at that index on pb_sample[7n+6:7n] combinationally, independently of the host address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, synchronous, active low, clears all state |
| soft_rst_n | input | 1 | Software reset, synchronous, active low, clears the address only |
| host_wr | input | 1 | Host write strobe for the selected register |
| host_sel | input | 2 | Register select: 0 address, 1 data, 2 broadcast, 3 none |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Combinational read of the selected register |
| pb_idx | input | 40 | Playback phase index, 5 bits per channel |
| pb_sample | output | 56 | Playback sample, 7 bits per channel |

## Verification
The assertions check on every cycle that a storage lane changes only when it receives a write to an in-range index, that out-of-range writes leave it unchanged, that the software reset clears the address while keeping the held sample, and that the unused select code leaves the registers alone. Only the bench scenarios can show that the data lands at the right channel and phase, that a broadcast reaches exactly the masked channels with the held value, that the extreme sample values round-trip exactly, and that reads of out-of-range indexes and of the broadcast register return zero.

// File: rtl/wt_pkg.sv
// Package: shared register select codes for the pulse-shape sample memory.
// Assumes a two-bit host select field; code 3 decodes to no register.
package wt_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_BCAST = 2'd2,
        SEL_NONE  = 2'd3
    } wt_sel_e;
endpackage

// File: rtl/wt_lane.sv
// Module: one channel's sample storage with a single write port, a host read
// port and a playback read port. Indexes at or above DEPTH hold no storage:
// writes to them are dropped and reads of them return zero.
// Assumes that the write enable is already qualified by the resets.
module wt_lane #(
    parameter int DEPTH = 24,
    parameter int SW    = 7,
    parameter int PHW   = 5
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           we_i,
    input  logic [PHW-1:0] widx_i,
    input  logic [SW-1:0]  wdata_i,
    input  logic [PHW-1:0] hidx_i,
    output logic [SW-1:0]  hdata_o,
    input  logic [PHW-1:0] pidx_i,
    output logic [SW-1:0]  pdata_o
);
    localparam logic [PHW:0] LIMIT = (PHW+1)'(DEPTH);

    logic [DEPTH-1:0][SW-1:0] mem_q;
    logic                     w_in_range;

    // Flags a write index that has storage behind it.
    always_comb w_in_range = ({1'b0, widx_i} < LIMIT);

    // Sample storage: cleared by power-up reset, written one entry per cycle.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            mem_q <= '0;
        end else if (we_i && w_in_range) begin
            mem_q[widx_i] <= wdata_i;
        end
    end

    // Host read port, zero outside the storage range.
    always_comb hdata_o = ({1'b0, hidx_i} < LIMIT) ? mem_q[hidx_i] : '0;

    // Playback read port, zero outside the storage range.
    always_comb pdata_o = ({1'b0, pidx_i} < LIMIT) ? mem_q[pidx_i] : '0;

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
        !we_i |=> $stable(mem_q));

    assert_oob_ignored_R4: assert property (@(posedge clk) disable iff (!por_n)
        (we_i && !w_in_range) |=> $stable(mem_q));
endmodule

// File: rtl/wt_regs.sv
// Module: host register file. It holds the address register and the held
// sample value, and it decodes host writes into a single-channel data strobe
// or a broadcast strobe. Both resets block host writes. The software reset
// clears only the address register.
// Assumes that host_wdata is valid in the cycle host_wr is high.
module wt_regs
    import wt_pkg::*;
#(
    parameter int NCH = 8,
    parameter int SW  = 7
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           soft_rst_n,
    input  logic           host_wr,
    input  logic [1:0]     host_sel,
    input  logic [7:0]     host_wdata,
    output logic [7:0]     addr_q,
    output logic [SW-1:0]  data_q,
    output logic           data_we_o,
    output logic           bcast_we_o,
    output logic [NCH-1:0] bcast_mask_o
);
    wt_sel_e sel;
    logic    wr_ok;

    // Decodes the select code and qualifies writes by both resets.
    always_comb begin
        sel          = wt_sel_e'(host_sel);
        wr_ok        = por_n && soft_rst_n && host_wr;
        data_we_o    = wr_ok && (sel == SEL_DATA);
        bcast_we_o   = wr_ok && (sel == SEL_BCAST);
        bcast_mask_o = host_wdata[NCH-1:0];
    end

    // Address register: cleared by either reset, loaded by an address write.
    always_ff @(posedge clk) begin
        if (!por_n || !soft_rst_n) begin
            addr_q <= '0;
        end else if (wr_ok && sel == SEL_ADDR) begin
            addr_q <= host_wdata;
        end
    end

    // Held sample: cleared by power-up reset only, drops reserved bit 7.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            data_q <= '0;
        end else if (data_we_o) begin
            data_q <= host_wdata[SW-1:0];
        end
    end

    assert_addr_cleared_R7: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst_n |=> (addr_q == 8'h00));

    assert_held_survives_R7: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst_n |=> $stable(data_q));

    assert_unused_sel_R9: assert property (@(posedge clk) disable iff (!por_n)
        (host_wr && host_sel == 2'd3) |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/wt_top.sv
// Module: top of the indirect pulse-shape sample memory. It routes the
// decoded host strobes to the per-channel lanes, writing one lane for a data
// write or every masked lane at once for a broadcast, and it muxes host reads.
// Assumes that NCH and DEPTH split the address byte exactly into channel and
// phase fields.
module wt_top
    import wt_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DEPTH = 24,
    parameter int SW    = 7
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      soft_rst_n,
    input  logic                      host_wr,
    input  logic [1:0]                host_sel,
    input  logic [7:0]                host_wdata,
    output logic [7:0]                host_rdata,
    input  logic [NCH*$clog2(DEPTH)-1:0] pb_idx,
    output logic [NCH*SW-1:0]         pb_sample
);
    localparam int CHW = $clog2(NCH);
    localparam int PHW = $clog2(DEPTH);

    logic [7:0]           addr_q;
    logic [SW-1:0]        data_q;
    logic                 data_we;
    logic                 bcast_we;
    logic [NCH-1:0]       bcast_mask;
    logic [CHW-1:0]       addr_ch;
    logic [PHW-1:0]       addr_ph;
    logic [SW-1:0]        lane_wd;
    logic [NCH-1:0]       lane_we;
    logic [NCH-1:0][SW-1:0] lane_hdata;
    logic [SW-1:0]        sel_sample;

    wt_regs #(.NCH(NCH), .SW(SW)) u_regs (
        .clk         (clk),
        .por_n       (por_n),
        .soft_rst_n  (soft_rst_n),
        .host_wr     (host_wr),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .addr_q      (addr_q),
        .data_q      (data_q),
        .data_we_o   (data_we),
        .bcast_we_o  (bcast_we),
        .bcast_mask_o(bcast_mask)
    );

    // Splits the address byte and picks the lane write value.
    always_comb begin
        addr_ch = addr_q[7 -: CHW];
        addr_ph = addr_q[PHW-1:0];
        lane_wd = data_we ? host_wdata[SW-1:0] : data_q;
    end

    for (genvar n = 0; n < NCH; n++) begin : g_lane
        // Lane write: addressed data write or masked broadcast.
        always_comb lane_we[n] = (data_we && addr_ch == CHW'(n)) ||
                                 (bcast_we && bcast_mask[n]);

        wt_lane #(.DEPTH(DEPTH), .SW(SW), .PHW(PHW)) u_lane (
            .clk    (clk),
            .por_n  (por_n),
            .we_i   (lane_we[n]),
            .widx_i (addr_ph),
            .wdata_i(lane_wd),
            .hidx_i (addr_ph),
            .hdata_o(lane_hdata[n]),
            .pidx_i (pb_idx[n*PHW +: PHW]),
            .pdata_o(pb_sample[n*SW +: SW])
        );
    end

    // Selects the addressed channel's sample for the data window.
    always_comb sel_sample = lane_hdata[addr_ch];

    // Host read mux; the broadcast strobe and the unused code read zero.
    always_comb begin
        case (wt_sel_e'(host_sel))
            SEL_ADDR: host_rdata = addr_q;
            SEL_DATA: host_rdata = {{(8-SW){1'b0}}, sel_sample};
            default:  host_rdata = 8'h00;
        endcase
    end
endmodule

// File: tb/wt_top_tb.sv
module wt_top_tb;
    localparam int NCH = 8;
    localparam int DEPTH = 24;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [39:0] pb_idx = '0;
    logic [55:0] pb_sample;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [6:0] exp_mem [NCH][32];
    logic [6:0] held = 7'h00;

    always #10 clk = ~clk;

    wt_top u_dut (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
        .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .pb_idx(pb_idx), .pb_sample(pb_sample)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] expv);
        total++;
        if (got !== expv) begin
            bad++;
            $display("FAIL %s got=%h expected=%h", req, got, expv);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        host_sel = sel;
        #1 val = host_rdata;
    endtask

    // Sets every playback index to ph and compares all channels against the model.
    task automatic pb_all(input string req, input int ph);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) pb_idx[c*5 +: 5] = 5'(ph);
        #1;
        for (int c = 0; c < NCH; c++)
            check(req, {1'b0, pb_sample[c*7 +: 7]}, {1'b0, exp_mem[c][ph]});
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCH; c++)
            for (int p = 0; p < 32; p++) exp_mem[c][p] = 7'h00;
        held = 7'h00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        clear_model();
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1/R7: reset state
        rd(2'd0, v); check("R1 addr after reset", v, 8'h00);
        rd(2'd1, v); check("R7 data after reset", v, 8'h00);
        pb_all("R7 samples after reset", 0);

        // R1: address readback over several patterns
        for (int i = 0; i < 8; i++) begin
            logic [7:0] a = 8'((i * 53 + 7) & 255);
            wr(2'd0, a);
            rd(2'd0, v); check("R1 addr readback", v, a);
        end

        // R2/R4/R8: sweep every channel and phase, bit 7 set on some writes
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < 32; p++) begin
                logic [7:0] d = 8'((c * 37 + p * 11 + 1) & 255);
                wr(2'd0, {3'(c), 5'(p)});
                wr(2'd1, d);
                held = d[6:0];
                if (p < DEPTH) exp_mem[c][p] = d[6:0];
                rd(2'd1, v);
                check(p < DEPTH ? "R2 R8 data readback" : "R4 oob host read", v, {1'b0, exp_mem[c][p]});
            end
        end
        // R10/R4: playback sweep, all indexes including out of range
        for (int p = 0; p < 32; p++) pb_all(p < DEPTH ? "R10 playback" : "R4 oob playback", p);

        // R3: extreme values
        wr(2'd0, {3'd7, 5'd23}); wr(2'd1, 8'h3F); exp_mem[7][23] = 7'h3F;
        wr(2'd0, {3'd0, 5'd0});  wr(2'd1, 8'h40); exp_mem[0][0] = 7'h40; held = 7'h40;
        pb_all("R3 extreme 3F", 23);
        pb_all("R3 extreme 40", 0);

        // R5/R6: broadcast held 40h into channels 0,2,5,7 at phase 9
        wr(2'd0, {3'd3, 5'd9});
        wr(2'd2, 8'hA5);
        for (int c = 0; c < NCH; c++) if (c == 0 || c == 2 || c == 5 || c == 7) exp_mem[c][9] = held;
        pb_all("R5 broadcast masked", 9);
        rd(2'd2, v); check("R6 broadcast reads zero", v, 8'h00);
        // R5: broadcast with a new held value to all channels at phase 23
        wr(2'd0, {3'd1, 5'd23}); wr(2'd1, 8'h15); exp_mem[1][23] = 7'h15; held = 7'h15;
        wr(2'd2, 8'hFF);
        for (int c = 0; c < NCH; c++) exp_mem[c][23] = held;
        pb_all("R5 broadcast all", 23);
        // R4: broadcast to an out-of-range phase changes nothing
        wr(2'd0, {3'd0, 5'd30});
        wr(2'd2, 8'hFF);
        for (int p = 0; p < 32; p++) pb_all("R4 oob broadcast", p);

        // R9: unused select code
        rd(2'd3, v); check("R9 unused read", v, 8'h00);
        wr(2'd0, 8'h45);
        wr(2'd3, 8'hFF);
        rd(2'd0, v); check("R9 unused write addr", v, 8'h45);
        rd(2'd1, v); check("R9 unused write data", v, {1'b0, exp_mem[2][5]});

        // R7: soft reset with a write attempt in progress
        wr(2'd0, {3'd3, 5'd4});
        @(negedge clk);
        soft_rst_n = 1'b0; host_wr = 1'b1; host_sel = 2'd1; host_wdata = 8'h11;
        repeat (2) @(negedge clk);
        soft_rst_n = 1'b1; host_wr = 1'b0;
        rd(2'd0, v); check("R7 soft reset clears addr", v, 8'h00);
        pb_all("R7 soft reset keeps samples", 4);
        wr(2'd2, 8'h02); exp_mem[1][0] = held;
        pb_all("R7 held sample survives soft reset", 0);

        // R7: power-up reset clears everything
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk); por_n = 1'b1;
        clear_model();
        for (int p = 0; p < 32; p++) pb_all("R7 power-up clears samples", p);
        wr(2'd2, 8'hFF);
        pb_all("R7 power-up clears held", 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule